// File: doc/BRIEF.md
# Privileged Tick Counter with Compare Interrupt

This block keeps a free-running count that advances by one on every cycle its tick-enable input is high. Beside the count it holds a compare register. When the live count reaches the armed target, it raises an interrupt request. That request stays pending until software clears it with a strobe. A single register port reaches both registers. The port carries a select bit, a write flag and a privilege flag, and read data comes back one cycle after the request.

The top bit has a different job in each register. In the counter it is a trap control: while it is set, an unprivileged read of the counter returns no data and pulses a trap flag instead. In the compare register it is an interrupt disable. A compare value with that bit set cannot arm the interrupt, and neither can a value of all zeros. A counter read shows only the trap control bit and the live count, so the compare disable never appears in it. The same parameterised block can serve as the processor tick, the system tick or the hypervisor tick.

Software arms the interrupt in three steps. It reads the count, adds a delta, and writes the sum to the compare register with the top bit clear. The block keeps the written value exactly as it arrived.

Top module: `tick_cmp_unit`

## Requirements
- R1: After reset the count is 0, the trap control bit is 0, the compare register reads 0x8000_0000_0000_0000 (disarmed) and irq is 0.
- R2: The count (bits 62:0) increases by one on each cycle with tick_en high. It holds when tick_en is low, and it wraps from 2^63-1 to 0 without touching bit 63.
- R3: A counter write (acc_sel=0) loads wdata[62:0] into the count and wdata[63] into the trap control bit. It takes priority over an increment in the same cycle.
- R4: A read (acc_valid=1, acc_write=0) gives rd_valid=1 on the next cycle. For a counter read, rd_data = {trap control bit, count} as they stood in the request cycle. The compare disable bit never shows in bit 63 of a counter read.
- R5: A compare write (acc_sel=1) stores all 64 bits exactly as written, and a compare read returns them unchanged.
- R6: An unprivileged (acc_priv=0) counter read while the trap control bit is 1 gives rd_trap=1 with rd_data=0 on the next cycle. A privileged read never traps, and neither does any read while the bit is 0.
- R7: When compare bit 63 is 0, the compare value is nonzero, and the count equals compare bits 62:0, irq is 1 from the next cycle on.
- R8: A compare value with bit 63 set, or equal to all zeros, never sets irq, even when the count passes its low bits.
- R9: irq stays set until irq_clr is high. A compare write does not clear it.
- R10: irq_clr takes priority over a match in the same cycle: irq is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count advance enable |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = counter register, 1 = compare register |
| acc_priv | input | 1 | Requester is privileged |
| acc_wdata | input | 64 | Write data |
| irq_clr | input | 1 | Clear the pending interrupt |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Read response data |
| rd_trap | output | 1 | Unprivileged counter read trapped |
| irq | output | 1 | Interrupt pending |

## Verification
The hardest case to reach is an exact 63-bit equality between the count and the armed target. Free counting from reset never gets near a random 63-bit value within the run. The stimulus therefore writes the counter a few ticks short of a compare value, or writes the compare as the current count plus a small delta. This drives matches, disarmed passes, wraps through zero, and a clear strobe in the very cycle of a match. Random traffic mixes in privileged and unprivileged reads with the trap control bit in both states.

// File: rtl/tick_pkg.sv
package tick_pkg;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_CMP   = 1'b1
    } reg_sel_e;

    localparam int unsigned TICK_CNT_W_DEFAULT = 63;

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int unsigned CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [CNT_W:0]   wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             npt_q
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             npt;
    } cstate_t;

    cstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cnt = wdata[CNT_W-1:0];
            st_d.npt = wdata[CNT_W];
        end else if (tick_en) begin
            st_d.cnt = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign npt_q = st_q.npt;

endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
    parameter int unsigned CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W:0]   wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             irq_clr,
    output logic [CNT_W:0]   cmp_q,
    output logic             pend_q
);

    typedef struct packed {
        logic [CNT_W:0] cmp;
        logic           pend;
    } pstate_t;

    pstate_t st_d, st_q;
    logic    armed;
    logic    hit;

    always_comb begin
        armed = !st_q.cmp[CNT_W] && (st_q.cmp != '0);
        hit   = armed && (cnt == st_q.cmp[CNT_W-1:0]);
        st_d  = st_q;
        if (wr_en) begin
            st_d.cmp = wdata;
        end
        if (irq_clr) begin
            st_d.pend = 1'b0;
        end else if (hit) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cmp  <= {1'b1, {CNT_W{1'b0}}};
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_q  = st_q.cmp;
    assign pend_q = st_q.pend;

endmodule

// File: rtl/tick_rdport.sv
module tick_rdport
    import tick_pkg::*;
#(
    parameter int unsigned CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  reg_sel_e         sel,
    input  logic             priv,
    input  logic [CNT_W-1:0] cnt,
    input  logic             npt,
    input  logic [CNT_W:0]   cmp,
    output logic             rd_valid,
    output logic [CNT_W:0]   rd_data,
    output logic             rd_trap
);

    typedef struct packed {
        logic           valid;
        logic [CNT_W:0] data;
        logic           trap;
    } rstate_t;

    rstate_t st_d, st_q;
    logic    deny;

    always_comb begin
        deny       = rd_req && (sel == SEL_COUNT) && !priv && npt;
        st_d.valid = rd_req;
        st_d.trap  = deny;
        if (!rd_req || deny) begin
            st_d.data = '0;
        end else if (sel == SEL_COUNT) begin
            st_d.data = {npt, cnt};
        end else begin
            st_d.data = cmp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.valid;
    assign rd_data  = st_q.data;
    assign rd_trap  = st_q.trap;

endmodule

// File: rtl/tick_cmp_unit.sv
module tick_cmp_unit
    import tick_pkg::*;
#(
    parameter int unsigned CNT_W = TICK_CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_sel,
    input  logic             acc_priv,
    input  logic [CNT_W:0]   acc_wdata,
    input  logic             irq_clr,
    output logic             rd_valid,
    output logic [CNT_W:0]   rd_data,
    output logic             rd_trap,
    output logic             irq
);

    localparam int unsigned REG_W = CNT_W + 1;

    reg_sel_e         sel;
    logic             cnt_wr, cmp_wr, rd_req;
    logic [CNT_W-1:0] cnt_w;
    logic             npt_w;
    logic [REG_W-1:0] cmp_w;

    always_comb begin
        sel    = reg_sel_e'(acc_sel);
        cnt_wr = acc_valid && acc_write && (sel == SEL_COUNT);
        cmp_wr = acc_valid && acc_write && (sel == SEL_CMP);
        rd_req = acc_valid && !acc_write;
    end

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (cnt_wr),
        .wdata   (acc_wdata),
        .cnt_q   (cnt_w),
        .npt_q   (npt_w)
    );

    tick_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmp_wr),
        .wdata   (acc_wdata),
        .cnt     (cnt_w),
        .irq_clr (irq_clr),
        .cmp_q   (cmp_w),
        .pend_q  (irq)
    );

    tick_rdport #(.CNT_W(CNT_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .sel      (sel),
        .priv     (acc_priv),
        .cnt      (cnt_w),
        .npt      (npt_w),
        .cmp      (cmp_w),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_trap  (rd_trap)
    );

endmodule

// File: rtl/tick_cmp_chk.sv
module tick_cmp_chk #(
    parameter int unsigned CNT_W = 63
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             acc_sel,
    input logic             acc_priv,
    input logic [CNT_W:0]   acc_wdata,
    input logic             irq_clr,
    input logic             rd_valid,
    input logic [CNT_W:0]   rd_data,
    input logic             rd_trap,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic             npt,
    input logic [CNT_W:0]   cmp
);

    logic past_ok;
    logic cnt_wr, rd_cnt_unpriv;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign cnt_wr        = acc_valid && acc_write && !acc_sel;
    assign rd_cnt_unpriv = acc_valid && !acc_write && !acc_sel && !acc_priv;

    // R2
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(tick_en && !cnt_wr) |-> cnt == CNT_W'($past(cnt) + 1'b1));

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cnt_wr) |-> {npt, cnt} == $past(acc_wdata));

    // R4
    rd_npt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && rd_valid && !rd_trap && $past(!acc_sel) |-> rd_data[CNT_W] == $past(npt));

    // R6
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && rd_trap |-> $past(rd_cnt_unpriv && npt));

    // R6
    priv_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(acc_priv) |-> !rd_trap);

    // R8
    rose_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(irq) |-> $past(!cmp[CNT_W] && cmp != '0 && cnt == cmp[CNT_W-1:0]));

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(irq && !irq_clr) |-> irq);

    // R10
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(irq_clr) |-> !irq);

endmodule

bind tick_cmp_unit tick_cmp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_sel   (acc_sel),
    .acc_priv  (acc_priv),
    .acc_wdata (acc_wdata),
    .irq_clr   (irq_clr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_trap   (rd_trap),
    .irq       (irq),
    .cnt       (cnt_w),
    .npt       (npt_w),
    .cmp       (cmp_w)
);

// File: tb/sim_tick_cmp_unit.sv
module sim_tick_cmp_unit;

    localparam int unsigned CW = 63;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic          acc_sel = 1'b0;
    logic          acc_priv = 1'b0;
    logic [CW:0]   acc_wdata = '0;
    logic          irq_clr = 1'b0;
    logic          rd_valid;
    logic [CW:0]   rd_data;
    logic          rd_trap;
    logic          irq;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    logic [CW-1:0] m_cnt = '0;
    logic          m_npt = 1'b0;
    logic [CW:0]   m_cmp = {1'b1, {CW{1'b0}}};
    logic          m_pend = 1'b0;

    always #10 clk = ~clk;

    tick_cmp_unit #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_sel(acc_sel), .acc_priv(acc_priv),
        .acc_wdata(acc_wdata), .irq_clr(irq_clr), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_trap(rd_trap), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [CW:0] act, input logic [CW:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model the edge, check at next negedge.
    task automatic step(input bit v, input bit w, input bit sel, input bit priv,
                        input logic [CW:0] data, input bit tk, input bit clr, input string tag);
        bit          e_rv, e_trap, hit;
        logic [CW:0] e_rd;
        acc_valid = v; acc_write = w; acc_sel = sel; acc_priv = priv;
        acc_wdata = data; tick_en = tk; irq_clr = clr;
        @(posedge clk);
        e_rv   = v && !w;
        e_trap = e_rv && !sel && !priv && m_npt;
        e_rd   = (!e_rv || e_trap) ? '0 : (sel ? m_cmp : {m_npt, m_cnt});
        hit    = !m_cmp[CW] && (m_cmp != '0) && (m_cnt == m_cmp[CW-1:0]);
        if (v && w && !sel) begin
            m_cnt = data[CW-1:0];
            m_npt = data[CW];
        end else if (tk) begin
            m_cnt = m_cnt + 1'b1;
        end
        if (v && w && sel) m_cmp = data;
        if (clr) m_pend = 1'b0;
        else if (hit) m_pend = 1'b1;
        @(negedge clk);
        chk(rd_valid == e_rv, {tag, " rd_valid"}, {63'd0, rd_valid}, {63'd0, e_rv});
        chk(rd_trap == e_trap, {tag, " rd_trap"}, {63'd0, rd_trap}, {63'd0, e_trap});
        if (e_rv) chk(rd_data == e_rd, {tag, " rd_data"}, rd_data, e_rd);
        chk(irq == m_pend, {tag, " irq"}, {63'd0, irq}, {63'd0, m_pend});
    endtask

    task automatic idle(input int n, input bit tk, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1, '0, tk, 0, tag);
    endtask

    task automatic wr(input bit sel, input logic [CW:0] d, input string tag);
        step(1, 1, sel, 1, d, 0, 0, tag);
    endtask

    task automatic rd(input bit sel, input bit priv, input string tag);
        step(1, 0, sel, priv, '0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [CW:0] base;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk(irq == 1'b0 && rd_valid == 1'b0, "R1 in reset", {63'd0, irq}, '0);
        rst_n = 1'b1;
        // R1 reset values
        rd(0, 1, "R1 count");
        rd(1, 1, "R1 compare");
        // R2 counting and hold
        idle(5, 1, "R2 tick");
        idle(3, 0, "R2 hold");
        rd(0, 1, "R2 count");
        // R3 write priority over tick
        step(1, 1, 0, 1, {1'b1, 63'h10}, 1, 0, "R3 load");
        rd(0, 1, "R3 readback");
        // R6 trap behaviour
        rd(0, 0, "R6 unpriv trap");
        rd(0, 1, "R6 priv");
        rd(1, 0, "R6 unpriv compare");
        wr(0, {1'b0, 63'h20}, "R6 clear npt");
        rd(0, 0, "R6 unpriv no npt");
        // R4 compare disable never seen in counter read
        wr(1, {1'b1, 63'h123}, "R4 compare");
        rd(0, 1, "R4 counter bit63");
        // R5 exact storage
        wr(1, 64'h1234_5678_9ABC_DEF0, "R5 write");
        rd(1, 1, "R5 read");
        // R7 arm and match
        wr(0, 64'd100, "R7 count");
        wr(1, 64'd105, "R7 arm");
        idle(10, 1, "R7 match");
        chk(irq == 1'b1, "R7 irq raised", {63'd0, irq}, 64'd1);
        // R9 sticky, compare write does not clear
        idle(4, 1, "R9 hold");
        wr(1, 64'd5000, "R9 compare write");
        chk(irq == 1'b1, "R9 after write", {63'd0, irq}, 64'd1);
        step(0, 0, 0, 1, '0, 0, 1, "R9 clear");
        chk(irq == 1'b0, "R9 cleared", {63'd0, irq}, '0);
        // R8 disabled compare
        wr(0, 64'd200, "R8 count");
        wr(1, {1'b1, 63'd203}, "R8 disabled");
        idle(8, 1, "R8 pass disabled");
        chk(irq == 1'b0, "R8 disabled no irq", {63'd0, irq}, '0);
        // R8 zero compare, R2 wrap
        wr(1, 64'd0, "R8 zero");
        wr(0, {1'b0, {(CW-2){1'b1}}, 2'b01}, "R2 near wrap");
        idle(5, 1, "R8 wrap pass");
        chk(irq == 1'b0, "R8 zero no irq", {63'd0, irq}, '0);
        rd(0, 1, "R2 wrapped");
        wr(0, {1'b1, {CW{1'b1}}}, "R2 npt wrap");
        idle(1, 1, "R2 npt wrap tick");
        rd(0, 1, "R2 npt kept");
        // R10 clear wins over match
        wr(0, 64'd50, "R10 count");
        wr(1, 64'd52, "R10 arm");
        idle(2, 1, "R10 reach");
        step(0, 0, 0, 1, '0, 0, 1, "R10 clear at match");
        chk(irq == 1'b0, "R10 cleared", {63'd0, irq}, '0);
        idle(1, 0, "R10 rematch");
        chk(irq == 1'b1, "R10 rematch", {63'd0, irq}, 64'd1);
        step(0, 0, 0, 1, '0, 1, 1, "R10 clear");
        // Random mix of traffic around armed targets
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom_range(0, 99);
            bit tk = $urandom_range(0, 3) != 0;
            bit cl = $urandom_range(0, 19) == 0;
            if (r < 4) begin
                base = {1'($urandom_range(0, 1)), 31'($urandom), 32'($urandom)};
                step(1, 1, 0, 1, base, tk, cl, "R3 random count");
            end else if (r < 10) begin
                base = {1'($urandom_range(0, 3) == 0), m_cnt + 63'($urandom_range(0, 12))};
                if ($urandom_range(0, 9) == 0) base = '0;
                step(1, 1, 1, 1, base, tk, cl, "R7 random arm");
            end else if (r < 30) begin
                step(1, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), '0, tk, cl, "R6 random read");
            end else begin
                step(0, 0, 0, 1, '0, tk, cl, "R7 random idle");
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule